// File: doc/BRIEF.md
# Floating-Point Operand Class Screen

This block sits in front of a floating-point datapath and decides, for each issued instruction, whether the datapath may run it. It classifies the source operands in single or double format. Operands the datapath does not handle are denormals and quiet NaNs. When either class appears in an operand that the instruction reads, the instruction is refused and treated as an unimplemented operation. The refusal blocks the destination write, sets a sticky cause bit in the control/status word and sends a floating-point exception request to the core. An opcode outside the implemented set takes the same trap path. Register-to-register moves copy bits unchanged, so the screen never applies to them.

All three decisions are registered. Each one appears in the clock cycle after the instruction is presented with `issue_valid` high. The control/status word is held inside the block. Software can load it through a write port, and that is the only way to clear the cause bit.

Top module: `fp_operand_screen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `proceed`, `dst_wr_en` and `fpe_req` are 0 and `ctrl_status` is all zero.
- R2: With `fmt_dbl`=0 the operand is the low 32 bits. It counts as denormal when bits [30:23] are all zero and bits [20:0] are not all zero. A value whose only set bits lie in [22:21] is not flagged.
- R3: With `fmt_dbl`=0, an operand whose bits [30:22] are all ones is a quiet NaN and is flagged.
- R4: With `fmt_dbl`=1, an operand whose bits [62:52] are all zero and whose bits [51:0] are not all zero is denormal and is flagged.
- R5: With `fmt_dbl`=1, an operand whose bits [62:51] are all ones is a quiet NaN and is flagged.
- R6: With `two_src`=1 both `src_a` and `src_b` are screened. With `two_src`=0 only `src_a` is screened, and the value of `src_b` has no effect on any output.
- R7: A flagged operand on an implemented, non-move instruction produces `fpe_req`=1, `dst_wr_en`=0 and `proceed`=0 in the next cycle.
- R8: An instruction with `op_known`=0 traps in the next cycle whatever its operands are, and whether or not it is a move.
- R9: An implemented move (`op_is_move`=1) never traps on operand class. In the next cycle it gives `dst_wr_en`=1 and `proceed`=0.
- R10: Zero, infinity, normal numbers and signaling NaNs (exponent all ones, top mantissa bit 0, rest nonzero) pass the screen. On an implemented non-move instruction they give `proceed`=1, `dst_wr_en`=1 and `fpe_req`=0.
- R11: `fpe_req` is high for exactly one cycle per trapping instruction. A cycle with `issue_valid`=0 yields all three decision outputs 0 in the next cycle.
- R12: Every trap sets bit 17 of `ctrl_status`. The bit stays set until a software write, and a trap in the same cycle as a software write leaves it set.
- R13: A software write with no trap in the same cycle loads `csr_wr_data` into `ctrl_status` in the next cycle, so writing 0 to bit 17 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| op_known | input | 1 | Opcode belongs to the implemented set |
| op_is_move | input | 1 | Instruction is a register move |
| fmt_dbl | input | 1 | 0 = single format, 1 = double format |
| two_src | input | 1 | Instruction reads both source operands |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| csr_wr_en | input | 1 | Software write to the control/status word |
| csr_wr_data | input | 32 | Data for the software write |
| proceed | output | 1 | Instruction is handed to the arithmetic datapath |
| dst_wr_en | output | 1 | Destination register write is allowed |
| fpe_req | output | 1 | Floating-point exception request, one-cycle pulse |
| ctrl_status | output | 32 | Control/status word, bit 17 = unimplemented-operation cause |

## Verification
A software load of the control/status word and a trap can land on the same clock edge. Both then update the word, and the cause bit must come out set while every other bit takes the written data. The bench provokes this with directed cases: a write that clears bit 17 is paired with a denormal operand, and a second pairing uses an unknown opcode. The random phase raises `csr_wr_en` on about a quarter of the issued instructions, so the overlap recurs throughout the run. Each result is judged against a control/status model in the bench, where the written value is applied first and the trap then forces bit 17.

// File: rtl/fpscr_pkg.sv
package fpscr_pkg;
  localparam int SGL_W       = 32;
  localparam int SGL_EXP_W   = 8;
  localparam int SGL_DEN_W   = 21;
  localparam int DBL_W       = 64;
  localparam int DBL_EXP_W   = 11;
  localparam int DBL_DEN_W   = 52;
  localparam int CSR_W       = 32;
  localparam int CAUSE_UNIMP = 17;
  localparam int NUM_SRC     = 2;

  typedef enum logic {
    FMT_SGL = 1'b0,
    FMT_DBL = 1'b1
  } fmt_e;

  typedef struct packed {
    logic denorm;
    logic qnan;
  } opclass_t;
endpackage

// File: rtl/fpscr_classify.sv
module fpscr_classify
  import fpscr_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int EXP_W  = 8,
  parameter int DEN_W  = 21
) (
  input  logic [WORD_W-1:0] value,
  output opclass_t          cls
);
  localparam int EXP_MSB = WORD_W - 2;
  localparam int EXP_LSB = WORD_W - 1 - EXP_W;
  localparam int QN_LSB  = EXP_LSB - 1;

  logic [EXP_W-1:0] exp_field;
  logic [EXP_W:0]   qn_field;
  logic [DEN_W-1:0] den_field;

  assign exp_field = value[EXP_MSB:EXP_LSB];
  assign qn_field  = value[EXP_MSB:QN_LSB];
  assign den_field = value[DEN_W-1:0];

  always_comb begin
    cls.denorm = (exp_field == '0) && (den_field != '0);
    cls.qnan   = &qn_field;
  end

  logic unused_sign;
  assign unused_sign = value[WORD_W-1];

  generate
    if (DEN_W < QN_LSB) begin : g_gap
      logic unused_gap;
      assign unused_gap = ^value[QN_LSB-1:DEN_W];
    end
  endgenerate
endmodule

// File: rtl/fpscr_screen.sv
module fpscr_screen
  import fpscr_pkg::*;
(
  input  logic             fmt_dbl,
  input  logic             two_src,
  input  logic [DBL_W-1:0] src_a,
  input  logic [DBL_W-1:0] src_b,
  output logic             opnd_flag
);
  logic [DBL_W-1:0]   opnd   [NUM_SRC];
  logic [NUM_SRC-1:0] bad_op;
  logic [NUM_SRC-1:0] use_op;

  assign opnd[0]   = src_a;
  assign opnd[1]   = src_b;
  assign use_op[0] = 1'b1;
  assign use_op[1] = two_src;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      opclass_t cls_s;
      opclass_t cls_d;

      fpscr_classify #(
        .WORD_W(SGL_W), .EXP_W(SGL_EXP_W), .DEN_W(SGL_DEN_W)
      ) i_cls_sgl (
        .value (opnd[g][SGL_W-1:0]),
        .cls   (cls_s)
      );

      fpscr_classify #(
        .WORD_W(DBL_W), .EXP_W(DBL_EXP_W), .DEN_W(DBL_DEN_W)
      ) i_cls_dbl (
        .value (opnd[g]),
        .cls   (cls_d)
      );

      always_comb begin
        if (fmt_e'(fmt_dbl) == FMT_DBL) bad_op[g] = use_op[g] & (cls_d.denorm | cls_d.qnan);
        else                            bad_op[g] = use_op[g] & (cls_s.denorm | cls_s.qnan);
      end
    end
  endgenerate

  assign opnd_flag = |bad_op;
endmodule

// File: rtl/fpscr_trap.sv
module fpscr_trap
  import fpscr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic             op_known,
  input  logic             op_is_move,
  input  logic             opnd_flag,
  input  logic             csr_wr_en,
  input  logic [CSR_W-1:0] csr_wr_data,
  output logic             proceed,
  output logic             dst_wr_en,
  output logic             fpe_req,
  output logic [CSR_W-1:0] ctrl_status
);
  logic             trap_d;
  logic             wr_d;
  logic             go_d;
  logic [CSR_W-1:0] csr_d;
  logic             csr_en;
  logic             proceed_q;
  logic             wr_q;
  logic             fpe_q;
  logic [CSR_W-1:0] csr_q;

  always_comb begin
    trap_d = issue_valid & (~op_known | (~op_is_move & opnd_flag));
    wr_d   = issue_valid & op_known & ~trap_d;
    go_d   = wr_d & ~op_is_move;
    csr_en = csr_wr_en | trap_d;
    csr_d  = csr_wr_en ? csr_wr_data : csr_q;
    if (trap_d) csr_d[CAUSE_UNIMP] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      proceed_q <= 1'b0;
      wr_q      <= 1'b0;
      fpe_q     <= 1'b0;
    end else begin
      proceed_q <= go_d;
      wr_q      <= wr_d;
      fpe_q     <= trap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      csr_q <= '0;
    else if (csr_en) csr_q <= csr_d;
  end

  assign proceed     = proceed_q;
  assign dst_wr_en   = wr_q;
  assign fpe_req     = fpe_q;
  assign ctrl_status = csr_q;
endmodule

// File: rtl/fp_operand_screen.sv
module fp_operand_screen
  import fpscr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic             op_known,
  input  logic             op_is_move,
  input  logic             fmt_dbl,
  input  logic             two_src,
  input  logic [63:0]      src_a,
  input  logic [63:0]      src_b,
  input  logic             csr_wr_en,
  input  logic [31:0]      csr_wr_data,
  output logic             proceed,
  output logic             dst_wr_en,
  output logic             fpe_req,
  output logic [31:0]      ctrl_status
);
  logic opnd_flag;

  fpscr_screen i_screen (
    .fmt_dbl   (fmt_dbl),
    .two_src   (two_src),
    .src_a     (src_a),
    .src_b     (src_b),
    .opnd_flag (opnd_flag)
  );

  fpscr_trap i_trap (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .op_known    (op_known),
    .op_is_move  (op_is_move),
    .opnd_flag   (opnd_flag),
    .csr_wr_en   (csr_wr_en),
    .csr_wr_data (csr_wr_data),
    .proceed     (proceed),
    .dst_wr_en   (dst_wr_en),
    .fpe_req     (fpe_req),
    .ctrl_status (ctrl_status)
  );
endmodule

// File: rtl/fpscr_checker.sv
module fpscr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        issue_valid,
  input logic        op_known,
  input logic        op_is_move,
  input logic        csr_wr_en,
  input logic        proceed,
  input logic        dst_wr_en,
  input logic        fpe_req,
  input logic [31:0] ctrl_status
);
  // R7
  trap_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fpe_req |-> (!dst_wr_en && !proceed));

  // R11
  req_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fpe_req |-> $past(issue_valid));

  // R12
  req_sets_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fpe_req |-> ctrl_status[17]);

  // R12
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_status[17]) && !$past(csr_wr_en)) |-> ctrl_status[17]);

  // R8
  unknown_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !op_known) |=> fpe_req);

  // R9
  move_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && op_known && op_is_move) |=> (dst_wr_en && !fpe_req && !proceed));

  // R9
  proceed_implies_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proceed |-> dst_wr_en);
endmodule

bind fp_operand_screen fpscr_checker i_fpscr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .op_known    (op_known),
  .op_is_move  (op_is_move),
  .csr_wr_en   (csr_wr_en),
  .proceed     (proceed),
  .dst_wr_en   (dst_wr_en),
  .fpe_req     (fpe_req),
  .ctrl_status (ctrl_status)
);

// File: tb/test_fp_operand_screen.sv
module test_fp_operand_screen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid, op_known, op_is_move, fmt_dbl, two_src;
  logic [63:0] src_a, src_b;
  logic        csr_wr_en;
  logic [31:0] csr_wr_data;
  logic        proceed, dst_wr_en, fpe_req;
  logic [31:0] ctrl_status;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;
  logic [31:0] m_csr;

  always #5 clk = ~clk;

  fp_operand_screen i_fp_operand_screen (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op_known(op_known),
    .op_is_move(op_is_move), .fmt_dbl(fmt_dbl), .two_src(two_src),
    .src_a(src_a), .src_b(src_b), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
    .proceed(proceed), .dst_wr_en(dst_wr_en), .fpe_req(fpe_req), .ctrl_status(ctrl_status)
  );

  function automatic bit bad_sgl(logic [31:0] v);  // R2 R3
    return ((v[30:23] == 8'h00) && (v[20:0] != 0)) || (&v[30:22]);
  endfunction

  function automatic bit bad_dbl(logic [63:0] v);  // R4 R5
    return ((v[62:52] == 11'h000) && (v[51:0] != 0)) || (&v[62:51]);
  endfunction

  function automatic bit bad_op(bit dbl, logic [63:0] v);
    return dbl ? bad_dbl(v) : bad_sgl(v[31:0]);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at negedge, sample one cycle later at the next negedge
  task automatic issue(string req, bit v, bit kn, bit mv, bit dbl, bit two,
                       logic [63:0] a, logic [63:0] b, bit we, logic [31:0] wd);
    bit flag, trap, ewr, ego;
    issue_valid = v; op_known = kn; op_is_move = mv; fmt_dbl = dbl; two_src = two;
    src_a = a; src_b = b; csr_wr_en = we; csr_wr_data = wd;
    flag = bad_op(dbl, a) || (two && bad_op(dbl, b));
    trap = v && (!kn || (!mv && flag));
    ewr  = v && kn && !trap;
    ego  = ewr && !mv;
    if (we) m_csr = wd;
    if (trap) m_csr[17] = 1'b1;
    @(negedge clk);
    issue_valid = 0; csr_wr_en = 0;
    chk(req, "fpe_req",     {31'd0, fpe_req},   {31'd0, trap});
    chk(req, "dst_wr_en",   {31'd0, dst_wr_en}, {31'd0, ewr});
    chk(req, "proceed",     {31'd0, proceed},   {31'd0, ego});
    chk(req, "ctrl_status", ctrl_status,        m_csr);
  endtask

  function automatic logic [63:0] mk_opnd(bit dbl, int cls);
    logic [63:0] r = {$urandom, $urandom};
    if (dbl) begin
      case (cls)
        0: r[62:0] = '0;
        1: r[62:52] = 11'h7ff & ((r[62:52] % 11'h7fe) + 11'h1);
        2: begin r[62:52] = '1; r[51:0] = '0; end
        3: begin r[62:51] = 12'hffe; r[50:0] = r[50:0] | 51'h1; end
        4: r[62:51] = '1;
        5: begin r[62:52] = '0; r[51:0] = r[51:0] | 52'h1; end
        default: ;
      endcase
    end else begin
      case (cls)
        0: r[30:0] = '0;
        1: r[30:23] = (r[30:23] % 8'hfe) + 8'h1;
        2: begin r[30:23] = '1; r[22:0] = '0; end
        3: begin r[30:22] = 9'h1fe; r[21:0] = r[21:0] | 22'h1; end
        4: r[30:22] = '1;
        5: begin r[30:23] = '0; r[20:0] = r[20:0] | 21'h1; end
        default: ;
      endcase
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; issue_valid = 0; op_known = 0; op_is_move = 0; fmt_dbl = 0; two_src = 0;
    src_a = '0; src_b = '0; csr_wr_en = 0; csr_wr_data = '0; m_csr = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {29'd0, fpe_req, dst_wr_en, proceed}, 32'd0);
    chk("R1", "reset csr", ctrl_status, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "after release", {29'd0, fpe_req, dst_wr_en, proceed}, 32'd0);

    // R10 pass classes
    issue("R10", 1, 1, 0, 0, 1, 64'h3f800000, 64'h0, 0, 0);
    issue("R10", 1, 1, 0, 0, 1, 64'h7f800000, 64'h80000000, 0, 0);
    issue("R10", 1, 1, 0, 0, 0, 64'h7f800001, 64'h0, 0, 0);
    issue("R10", 1, 1, 0, 1, 1, 64'h7ff0000000000001, 64'h3ff0000000000000, 0, 0);
    // R2 single denormal and the ignored bits 22:21
    issue("R2", 1, 1, 0, 0, 0, 64'h00000001, 64'h0, 0, 0);
    issue("R2", 1, 1, 0, 0, 0, 64'h00600000, 64'h0, 0, 0);
    issue("R13", 1, 0, 0, 0, 0, 64'h0, 64'h0, 1, 32'h0);
    // R3 single quiet NaN, in operand b
    issue("R3", 1, 1, 0, 0, 1, 64'h3f800000, 64'h7fc00000, 1, 32'h0000_00a5);
    // R4 / R5 double
    issue("R13", 1, 1, 0, 1, 0, 64'h0, 64'h0, 1, 32'h0);
    issue("R4", 1, 1, 0, 1, 1, 64'h0, 64'h0000000000000001, 0, 0);
    issue("R5", 1, 1, 0, 1, 0, 64'hfff8000000000000, 64'h0, 0, 0);
    issue("R5", 1, 1, 0, 1, 0, 64'h00000000ffc00000, 64'h0, 0, 0);  // single qNaN bits, double mode
    // R6 single-source ignores b
    issue("R13", 1, 1, 0, 0, 0, 64'h0, 64'h0, 1, 32'h0);
    issue("R6", 1, 1, 0, 0, 0, 64'h40000000, 64'h7fc00000, 0, 0);
    issue("R6", 1, 1, 0, 1, 0, 64'h4000000000000000, 64'h0000000000000001, 0, 0);
    // R9 move with qNaN
    issue("R9", 1, 1, 1, 0, 0, 64'h7fc00000, 64'h0, 0, 0);
    // R8 unknown opcode, including a move
    issue("R8", 1, 0, 0, 0, 1, 64'h3f800000, 64'h3f800000, 0, 0);
    issue("R8", 1, 0, 1, 1, 0, 64'h0, 64'h0, 0, 0);
    // R11 idle cycle after a trap: pulse ends
    issue("R11", 0, 1, 0, 0, 0, 64'h7fc00000, 64'h0, 0, 0);
    // R12 sticky across idle and passing ops
    issue("R12", 1, 1, 0, 0, 1, 64'h3f800000, 64'h3f800000, 0, 0);
    // R12 write clearing bit 17 together with a trap
    issue("R12", 1, 1, 0, 0, 0, 64'h00000010, 64'h0, 1, 32'h0000_1234);
    issue("R12", 1, 0, 0, 0, 0, 64'h0, 64'h0, 1, 32'hfffd_ffff);
    // R13 plain write clears it
    issue("R13", 0, 0, 0, 0, 0, 64'h0, 64'h0, 1, 32'h0000_00ff);

    for (int i = 0; i < 400; i++) begin
      bit dbl = $urandom_range(0, 1);
      bit two = $urandom_range(0, 1);
      issue("R7", $urandom_range(0, 7) != 0, $urandom_range(0, 9) != 0,
            $urandom_range(0, 7) == 0, dbl, two,
            mk_opnd(dbl, $urandom_range(0, 6)), mk_opnd(dbl, $urandom_range(0, 6)),
            $urandom_range(0, 3) == 0, $urandom);
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule